// File: doc/BRIEF.md
# Video Controller CPU Register Port

This block is the processor-facing side of a tile-based video controller. The processor sees eight byte-wide register slots selected by a 3-bit index. Through them it sets rendering control and mask bytes and polls a status byte that carries the vertical-blank flag. It also loads a scroll position and a video-memory address and streams bytes to and from video memory through a data slot that steps the address by itself.

Scroll and address values are wider than one byte, so each takes two writes. One shared toggle tracks whether the next write to either slot is the first or the second. The bytes land in bit fields of a 15-bit staging address: coarse X in bits 4:0, coarse Y in bits 9:5, nametable select in bits 11:10 and fine Y in bits 14:12. A separate 3-bit fine X holds the sub-tile horizontal scroll. The second address write copies the staging address into the live address that the data slot uses. A read of the status slot puts the toggle back to "first write", which lets software resynchronise it.

Read data comes from a one-byte bus latch. Reads of readable slots refill the latch; reads of write-only slots leave it unchanged and return what it holds. Video memory sits outside the block. It sees `vram_addr` together with one-cycle read or write strobes and answers reads combinationally on `vram_rdata`.

Top module: `vid_regport`

## Requirements
- R1: Synchronous active-high reset clears the control and mask bytes, the vblank flag, the bus latch, the toggle (to "first write"), the staging address, the live address and fine X to zero.
- R2: A read of index 2 loads the latch with the vblank flag in bit 7 and zeros in bits 6:0. It clears the vblank flag unless `vblank_set` is high in the same cycle, and it returns the toggle to "first write".
- R3: Every write to index 5 (scroll) or index 6 (address) inverts the single toggle that both slots share. No other access changes the toggle, except the status read of R2.
- R4: A first scroll write puts data bits 7:3 in staging bits 4:0 and data bits 2:0 in fine X. A second scroll write puts data bits 7:3 in staging bits 9:5 and data bits 2:0 in staging bits 14:12.
- R5: A first address write puts data bits 5:0 in staging bits 13:8 and clears staging bit 14. It leaves staging bits 7:0 unchanged.
- R6: A second address write replaces staging bits 7:0 with the data and copies the resulting 15-bit staging value into the live address. Apart from this and R8, the live address does not change.
- R7: A write to index 0 stores the control byte and copies its bits 1:0 into staging bits 11:10. A write to index 1 stores the mask byte.
- R8: Each access to index 7, read or write, presents live address bits 13:0 on `vram_addr` with a one-cycle `vram_rd` or `vram_wr` strobe (write data on `vram_wdata`). It then advances the live address modulo 2^15, by 32 when control bit 2 is set and by 1 otherwise.
- R9: A read of index 7 loads the latch with `vram_rdata` for the address presented in that cycle.
- R10: Reads of index 0 and index 1 load the latch with the stored control and mask bytes. Reads of indices 3, 4, 5 and 6 leave the latch and `rd_data` unchanged.
- R11: When `cpu_rd` and `cpu_wr` are high together, only the write takes effect, so `vram_rd` and `vram_wr` are never high together.
- R12: `vblank_set` sets the vblank flag and `vblank_clr` clears it. Set wins over any clear in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel | input | 3 | Register slot index |
| cpu_rd | input | 1 | Processor read strobe, one cycle per access |
| cpu_wr | input | 1 | Processor write strobe, one cycle per access |
| cpu_wdata | input | 8 | Processor write data |
| vblank_set | input | 1 | Pulse from the frame timer at the start of vertical blank |
| vblank_clr | input | 1 | Pulse from the frame timer at the end of vertical blank |
| vram_rdata | input | 8 | Video memory read data for `vram_addr` |
| rd_data | output | 8 | Bus latch contents |
| vram_addr | output | 14 | Video memory address (live address bits 13:0) |
| vram_rd | output | 1 | Video memory read strobe |
| vram_wr | output | 1 | Video memory write strobe |
| vram_wdata | output | 8 | Video memory write data |
| cur_addr | output | 15 | Live scroll/address register |
| tmp_addr | output | 15 | Staging scroll/address register |
| fine_x | output | 3 | Fine horizontal scroll |

## Verification
The hardest case to reach is a toggle that is out of step with the software's intent. That happens when a status read lands between the two halves of an address pair, or when scroll and address writes alternate, so that a byte meant as a high half is taken as a low half. The stimulus builds these sequences on purpose: a lone address write followed by a status read, then a full pair; and a scroll write followed straight away by an address write. After these come a long run of random slot, direction and data choices. Every cycle of that run is compared against a behavioural model, so address commits from a mistaken toggle state show up at once. A vblank pulse in the same cycle as a status read, and a data-port step across the 14-bit memory boundary, are also driven explicitly.

// File: rtl/vid_regport_pkg.sv
package vid_regport_pkg;

  typedef enum logic [2:0] {
    SEL_CTRL = 3'd0,
    SEL_MASK = 3'd1,
    SEL_STAT = 3'd2,
    SEL_RSV3 = 3'd3,
    SEL_RSV4 = 3'd4,
    SEL_SCRL = 3'd5,
    SEL_ADDR = 3'd6,
    SEL_DATA = 3'd7
  } reg_sel_e;

  typedef struct packed {
    logic ctrl_wr;
    logic mask_wr;
    logic scrl_wr;
    logic addr_wr;
    logic data_wr;
    logic ctrl_rd;
    logic mask_rd;
    logic stat_rd;
    logic data_rd;
  } access_s;

  localparam int CX_LO = 0;
  localparam int CY_LO = 5;
  localparam int NT_LO = 10;
  localparam int FY_LO = 12;
  localparam int STEP_BIT = 2;

endpackage

// File: rtl/vid_access_decode.sv
module vid_access_decode
  import vid_regport_pkg::*;
(
  input  logic [2:0] reg_sel,
  input  logic       cpu_rd,
  input  logic       cpu_wr,
  output access_s    acc
);

  reg_sel_e sel;
  logic     rd_only;

  always_comb begin
    sel     = reg_sel_e'(reg_sel);
    rd_only = cpu_rd && !cpu_wr;
    acc     = '0;
    acc.ctrl_wr = cpu_wr  && (sel == SEL_CTRL);
    acc.mask_wr = cpu_wr  && (sel == SEL_MASK);
    acc.scrl_wr = cpu_wr  && (sel == SEL_SCRL);
    acc.addr_wr = cpu_wr  && (sel == SEL_ADDR);
    acc.data_wr = cpu_wr  && (sel == SEL_DATA);
    acc.ctrl_rd = rd_only && (sel == SEL_CTRL);
    acc.mask_rd = rd_only && (sel == SEL_MASK);
    acc.stat_rd = rd_only && (sel == SEL_STAT);
    acc.data_rd = rd_only && (sel == SEL_DATA);
  end

endmodule

// File: rtl/vid_reg_bank.sv
module vid_reg_bank #(
  parameter int DW        = 8,
  parameter int VBLANK_BIT = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ctrl_wr,
  input  logic          mask_wr,
  input  logic          ctrl_rd,
  input  logic          mask_rd,
  input  logic          stat_rd,
  input  logic          data_rd,
  input  logic          vblank_set,
  input  logic          vblank_clr,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic [DW-1:0] ctrl_q,
  output logic          vblank_q,
  output logic [DW-1:0] latch_q
);

  logic [DW-1:0] mask_q;
  logic [DW-1:0] stat_word;

  always_comb begin
    stat_word             = '0;
    stat_word[VBLANK_BIT] = vblank_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= '0;
      mask_q   <= '0;
      vblank_q <= 1'b0;
      latch_q  <= '0;
    end else begin
      if (ctrl_wr) ctrl_q <= wdata;
      if (mask_wr) mask_q <= wdata;

      if (vblank_set)                  vblank_q <= 1'b1;
      else if (vblank_clr || stat_rd)  vblank_q <= 1'b0;

      if (ctrl_rd)      latch_q <= ctrl_q;
      else if (mask_rd) latch_q <= mask_q;
      else if (stat_rd) latch_q <= stat_word;
      else if (data_rd) latch_q <= mem_rdata;
    end
  end

endmodule

// File: rtl/vid_scroll_addr.sv
module vid_scroll_addr
  import vid_regport_pkg::*;
#(
  parameter int AW       = 15,
  parameter int DW       = 8,
  parameter int ROW_STEP = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ctrl_wr,
  input  logic          scrl_wr,
  input  logic          addr_wr,
  input  logic          data_acc,
  input  logic          stat_rd,
  input  logic          step_row,
  input  logic [DW-1:0] wdata,
  output logic [AW-1:0] cur_q,
  output logic [AW-1:0] tmp_q,
  output logic [2:0]    fine_x_q,
  output logic          second_q
);

  localparam int HI_W = AW - DW;

  logic [AW-1:0] step;

  assign step = step_row ? AW'(ROW_STEP) : AW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q    <= '0;
      tmp_q    <= '0;
      fine_x_q <= '0;
      second_q <= 1'b0;
    end else begin
      if (stat_rd)                 second_q <= 1'b0;
      else if (scrl_wr || addr_wr) second_q <= ~second_q;

      if (ctrl_wr) tmp_q[NT_LO +: 2] <= wdata[1:0];

      if (scrl_wr) begin
        if (!second_q) begin
          tmp_q[CX_LO +: 5] <= wdata[7:3];
          fine_x_q          <= wdata[2:0];
        end else begin
          tmp_q[CY_LO +: 5] <= wdata[7:3];
          tmp_q[FY_LO +: 3] <= wdata[2:0];
        end
      end

      if (addr_wr) begin
        if (!second_q) begin
          tmp_q[AW-1]           <= 1'b0;
          tmp_q[DW +: HI_W-1]   <= wdata[HI_W-2:0];
        end else begin
          tmp_q[DW-1:0] <= wdata;
          cur_q         <= {tmp_q[AW-1:DW], wdata};
        end
      end

      if (data_acc) cur_q <= cur_q + step;
    end
  end

endmodule

// File: rtl/vid_regport.sv
module vid_regport
  import vid_regport_pkg::*;
#(
  parameter int AW       = 15,
  parameter int DW       = 8,
  parameter int MW       = 14,
  parameter int ROW_STEP = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [2:0]    reg_sel,
  input  logic          cpu_rd,
  input  logic          cpu_wr,
  input  logic [DW-1:0] cpu_wdata,
  input  logic          vblank_set,
  input  logic          vblank_clr,
  input  logic [DW-1:0] vram_rdata,
  output logic [DW-1:0] rd_data,
  output logic [MW-1:0] vram_addr,
  output logic          vram_rd,
  output logic          vram_wr,
  output logic [DW-1:0] vram_wdata,
  output logic [AW-1:0] cur_addr,
  output logic [AW-1:0] tmp_addr,
  output logic [2:0]    fine_x
);

  access_s       acc;
  logic [DW-1:0] ctrl_q;
  logic          vblank_q;
  logic          wr_second;
  logic          step_row;

  assign step_row = ctrl_q[STEP_BIT];

  vid_access_decode u_dec (
    .reg_sel (reg_sel),
    .cpu_rd  (cpu_rd),
    .cpu_wr  (cpu_wr),
    .acc     (acc)
  );

  vid_reg_bank #(.DW(DW)) u_bank (
    .clk        (clk),
    .rst        (rst),
    .ctrl_wr    (acc.ctrl_wr),
    .mask_wr    (acc.mask_wr),
    .ctrl_rd    (acc.ctrl_rd),
    .mask_rd    (acc.mask_rd),
    .stat_rd    (acc.stat_rd),
    .data_rd    (acc.data_rd),
    .vblank_set (vblank_set),
    .vblank_clr (vblank_clr),
    .wdata      (cpu_wdata),
    .mem_rdata  (vram_rdata),
    .ctrl_q     (ctrl_q),
    .vblank_q   (vblank_q),
    .latch_q    (rd_data)
  );

  vid_scroll_addr #(.AW(AW), .DW(DW), .ROW_STEP(ROW_STEP)) u_addr (
    .clk      (clk),
    .rst      (rst),
    .ctrl_wr  (acc.ctrl_wr),
    .scrl_wr  (acc.scrl_wr),
    .addr_wr  (acc.addr_wr),
    .data_acc (acc.data_wr || acc.data_rd),
    .stat_rd  (acc.stat_rd),
    .step_row (step_row),
    .wdata    (cpu_wdata),
    .cur_q    (cur_addr),
    .tmp_q    (tmp_addr),
    .fine_x_q (fine_x),
    .second_q (wr_second)
  );

  assign vram_addr  = cur_addr[MW-1:0];
  assign vram_rd    = acc.data_rd;
  assign vram_wr    = acc.data_wr;
  assign vram_wdata = cpu_wdata;

endmodule

// File: rtl/vid_regport_chk.sv
module vid_regport_chk #(
  parameter int AW       = 15,
  parameter int ROW_STEP = 32
) (
  input logic          clk,
  input logic          rst,
  input logic [2:0]    reg_sel,
  input logic          cpu_rd,
  input logic          cpu_wr,
  input logic          vblank_set,
  input logic          vram_rd,
  input logic          vram_wr,
  input logic [AW-1:0] cur_addr,
  input logic [AW-1:0] tmp_addr,
  input logic          wr_second,
  input logic          step_row,
  input logic          vblank_q
);

  logic stat_rd, pair_wr, addr_commit, data_acc;

  assign stat_rd     = cpu_rd && !cpu_wr && (reg_sel == 3'd2);
  assign pair_wr     = cpu_wr && ((reg_sel == 3'd5) || (reg_sel == 3'd6));
  assign addr_commit = cpu_wr && (reg_sel == 3'd6) && wr_second;
  assign data_acc    = (cpu_rd || cpu_wr) && (reg_sel == 3'd7);

  assert_stat_read_clears_R2: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && !vblank_set) |=> (!vblank_q && !wr_second));

  assert_toggle_flips_R3: assert property (@(posedge clk) disable iff (rst)
    pair_wr |=> (wr_second != $past(wr_second)));

  assert_addr_commit_R6: assert property (@(posedge clk) disable iff (rst)
    addr_commit |=> (cur_addr == tmp_addr));

  assert_cur_holds_R6: assert property (@(posedge clk) disable iff (rst)
    (!data_acc && !addr_commit) |=> $stable(cur_addr));

  assert_data_step_R8: assert property (@(posedge clk) disable iff (rst)
    data_acc |=> (cur_addr == $past(cur_addr) + ($past(step_row) ? AW'(ROW_STEP) : AW'(1))));

  assert_strobe_excl_R11: assert property (@(posedge clk) disable iff (rst)
    !(vram_rd && vram_wr));

  assert_vblank_set_R12: assert property (@(posedge clk) disable iff (rst)
    vblank_set |=> vblank_q);

endmodule

bind vid_regport vid_regport_chk #(.AW(AW), .ROW_STEP(ROW_STEP)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .reg_sel    (reg_sel),
  .cpu_rd     (cpu_rd),
  .cpu_wr     (cpu_wr),
  .vblank_set (vblank_set),
  .vram_rd    (vram_rd),
  .vram_wr    (vram_wr),
  .cur_addr   (cur_addr),
  .tmp_addr   (tmp_addr),
  .wr_second  (wr_second),
  .step_row   (step_row),
  .vblank_q   (vblank_q)
);

// File: tb/vid_regport_tb.sv
`timescale 1ns/1ps
module vid_regport_tb;

  logic       clk = 1'b0;
  logic       rst;
  logic [2:0] reg_sel;
  logic       cpu_rd, cpu_wr, vblank_set, vblank_clr;
  logic [7:0] cpu_wdata, vram_rdata, rd_data, vram_wdata;
  logic [13:0] vram_addr;
  logic       vram_rd, vram_wr;
  logic [14:0] cur_addr, tmp_addr;
  logic [2:0] fine_x;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [7:0] mem [0:1023];

  int m_ctrl, m_mask, m_vb, m_latch, m_tog, m_t, m_v, m_fx;

  always #4 clk = ~clk;

  vid_regport u_dut (
    .clk(clk), .rst(rst), .reg_sel(reg_sel), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
    .cpu_wdata(cpu_wdata), .vblank_set(vblank_set), .vblank_clr(vblank_clr),
    .vram_rdata(vram_rdata), .rd_data(rd_data), .vram_addr(vram_addr),
    .vram_rd(vram_rd), .vram_wr(vram_wr), .vram_wdata(vram_wdata),
    .cur_addr(cur_addr), .tmp_addr(tmp_addr), .fine_x(fine_x)
  );

  assign vram_rdata = mem[vram_addr[9:0]];

  always @(posedge clk) if (vram_wr) mem[vram_addr[9:0]] <= vram_wdata;

  task automatic chk(string tag, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic cmp_all(string tag);
    chk(tag, "rd_data",  int'(rd_data),  m_latch);
    chk(tag, "cur_addr", int'(cur_addr), m_v);
    chk(tag, "tmp_addr", int'(tmp_addr), m_t);
    chk(tag, "fine_x",   int'(fine_x),   m_fx);
  endtask

  task automatic op(string tag, int sel, bit rd, bit wr, int d, bit vs = 0, bit vc = 0);
    int step;
    @(negedge clk);
    reg_sel = 3'(sel); cpu_rd = rd; cpu_wr = wr; cpu_wdata = 8'(d);
    vblank_set = vs; vblank_clr = vc;
    #1;
    chk("R11", "vram_wr", int'(vram_wr), (wr && sel == 7) ? 1 : 0);
    chk("R8",  "vram_rd", int'(vram_rd), (!wr && rd && sel == 7) ? 1 : 0);
    if (sel == 7 && (rd || wr)) chk("R8", "vram_addr", int'(vram_addr), m_v & 16'h3FFF);
    step = (m_ctrl & 4) ? 32 : 1;
    if (wr) begin
      case (sel)
        0: begin m_ctrl = d; m_t = (m_t & ~(3 << 10)) | ((d & 3) << 10); end
        1: m_mask = d;
        5: begin
          if (m_tog == 0) begin m_t = (m_t & ~31) | (d >> 3); m_fx = d & 7; end
          else m_t = (m_t & ~(31 << 5) & ~(7 << 12)) | ((d >> 3) << 5) | ((d & 7) << 12);
          m_tog ^= 1;
        end
        6: begin
          if (m_tog == 0) m_t = (m_t & 255) | ((d & 63) << 8);
          else begin m_t = (m_t & ~255) | d; m_v = m_t; end
          m_tog ^= 1;
        end
        7: m_v = (m_v + step) & 32767;
        default: ;
      endcase
    end else if (rd) begin
      case (sel)
        0: m_latch = m_ctrl;
        1: m_latch = m_mask;
        2: begin m_latch = m_vb ? 128 : 0; m_vb = 0; m_tog = 0; end
        7: begin m_latch = int'(mem[m_v & 1023]); m_v = (m_v + step) & 32767; end
        default: ;
      endcase
    end
    if (vs) m_vb = 1; else if (vc) m_vb = 0;
    @(posedge clk); #1;
    cmp_all(tag);
    cpu_rd = 0; cpu_wr = 0; vblank_set = 0; vblank_clr = 0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 8'((i * 13) ^ (i >> 3));
    rst = 1; reg_sel = 0; cpu_rd = 0; cpu_wr = 0; cpu_wdata = 0;
    vblank_set = 0; vblank_clr = 0;
    m_ctrl = 0; m_mask = 0; m_vb = 0; m_latch = 0; m_tog = 0; m_t = 0; m_v = 0; m_fx = 0;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    cmp_all("R1");
    op("R2", 2, 1, 0, 0);

    op("R7", 0, 0, 1, 8'h03);
    op("R10", 0, 1, 0, 0);
    op("R7", 1, 0, 1, 8'h5A);
    op("R10", 1, 1, 0, 0);
    op("R10", 3, 1, 0, 0);
    op("R10", 5, 1, 0, 0);

    op("R4", 5, 0, 1, 8'hAD);
    op("R4", 5, 0, 1, 8'h5E);
    op("R5", 6, 0, 1, 8'hFF);
    op("R6", 6, 0, 1, 8'h10);

    op("R5", 6, 0, 1, 8'h21);
    op("R2", 2, 1, 0, 0);
    op("R3", 6, 0, 1, 8'h02);
    op("R6", 6, 0, 1, 8'h08);

    op("R3", 5, 0, 1, 8'h17);
    op("R3", 6, 0, 1, 8'h33);
    op("R2", 2, 1, 0, 0);

    op("R7", 0, 0, 1, 8'h00);
    op("R8", 7, 0, 1, 8'hC4);
    op("R8", 7, 0, 1, 8'h3B);
    op("R5", 6, 0, 1, 8'h02);
    op("R6", 6, 0, 1, 8'h08);
    op("R9", 7, 1, 0, 0);
    op("R9", 7, 1, 0, 0);
    op("R7", 0, 0, 1, 8'h04);
    op("R8", 7, 1, 0, 0);
    op("R8", 7, 0, 1, 8'h77);

    op("R5", 6, 0, 1, 8'h3F);
    op("R6", 6, 0, 1, 8'hFF);
    op("R7", 0, 0, 1, 8'h00);
    op("R8", 7, 1, 0, 0);
    op("R8", 7, 1, 0, 0);

    op("R11", 7, 1, 1, 8'h99);
    op("R11", 2, 1, 1, 8'h00);

    op("R12", 4, 0, 0, 0, 1, 0);
    op("R2", 2, 1, 0, 0);
    op("R2", 2, 1, 0, 0);
    op("R12", 4, 0, 0, 0, 1, 0);
    op("R12", 2, 1, 0, 0, 1, 0);
    op("R12", 2, 1, 0, 0);
    op("R12", 4, 0, 0, 0, 1, 1);
    op("R12", 4, 0, 0, 0, 0, 1);
    op("R12", 2, 1, 0, 0);

    for (int n = 0; n < 400; n++) begin
      int s, k;
      s = int'($urandom_range(0, 7));
      k = int'($urandom_range(0, 3));
      op("R3", s, k[0], k[1], int'($urandom_range(0, 255)),
         ($urandom_range(0, 7) == 0), ($urandom_range(0, 7) == 0));
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule